// File: doc/BRIEF.md
# Shared-Bus Oscillator and Level DAC Loader

This block serialises two kinds of settings onto one shared two-wire bus made of a serial clock line and a serial data line. One target is a numerically controlled oscillator that takes a 32-bit tuning word and then needs a separate transfer strobe before the new word takes effect. The other target is a 12-bit DAC that sets an output level and takes a 16-bit frame. Each target has its own active-low select. The two targets capture on opposite clock phases. The oscillator samples on rising edges. The DAC samples on falling edges and expects the clock to be parked high before its select drops.

A client pulses `nco_start` with a tuning word, or `dac_start` with a level. Each request goes into a one-deep slot for its target and is issued once the bus is free. The bus is free when no frame of this block is running and the other bus master does not hold `ext_busy`. While a frame is on the wire the block raises `busy`, and it pulses `done` for one cycle when the frame ends. After reset the block loads a power-up level first and a power-up tuning word second, with no request needed.

Every bus step lasts `DIV` clock cycles, so no two bus-line changes are closer together than `DIV` cycles.

Top module: `osc_dac_loader`

## Requirements
- R1: While reset is held, and whenever `busy` is low, `nco_sel_n`, `dac_sel_n` and `nco_xfer_n` are 1, and `sclk` and `sdata` are 0.
- R2: An oscillator frame first drives `nco_sel_n` low. It then presents 32 bits on `sdata`, each valid at a rising `sclk` edge, in this order: `nco_word[31:24]` is byte 0 and goes first, and each byte is sent MSB first. After the last bit, `sclk` returns low. `nco_xfer_n` then pulses low and back high while `nco_sel_n` is still low. Only after that does `nco_sel_n` return high.
- R3: A DAC frame raises `sclk` before `dac_sel_n` falls. It then presents 16 bits, each valid at a falling `sclk` edge and MSB first. The first 4 bits are 0 and the last 12 bits are `dac_level[11:0]`. Each bit is followed by a rising edge. After the frame, `dac_sel_n` returns high and only then does `sclk` go low.
- R4: After reset, with no request, the block sends a DAC frame with level 2783 and then an oscillator frame with the word 0x447AE147 (bytes 68, 122, 225, 71).
- R5: A start that arrives while the bus is not free is held and issued later. If a second start for the same target arrives before the first has been issued, only the newer value is sent.
- R6: When requests for both targets are waiting, the DAC frame is issued before the oscillator frame.
- R7: No frame begins in a cycle after one in which `ext_busy` was high. `busy` is high from the first bus step of a frame until the frame ends.
- R8: Two successive changes on any of the five bus outputs are at least `DIV` clock cycles apart.
- R9: `done` pulses high for one cycle at the end of each frame, with `busy` low, exactly once per frame.
- R10: At most one of `nco_sel_n` and `dac_sel_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nco_start | input | 1 | One-cycle request to load `nco_word` |
| nco_word | input | 32 | Oscillator tuning word; bits 31:24 are byte 0 |
| dac_start | input | 1 | One-cycle request to load `dac_level` |
| dac_level | input | 12 | DAC level code, 0 to 4095 |
| ext_busy | input | 1 | Other bus master owns the shared lines; no frame may start |
| busy | output | 1 | A frame of this block is on the bus |
| sclk | output | 1 | Shared serial clock |
| sdata | output | 1 | Shared serial data |
| nco_sel_n | output | 1 | Oscillator select, active low |
| nco_xfer_n | output | 1 | Oscillator transfer strobe, active low |
| dac_sel_n | output | 1 | DAC select, active low |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with `DIV` = 3. This keeps each oscillator frame near two hundred cycles, so the power-up pair, several words and levels, and the queueing scenarios all fit in a short run. Because `DIV` is above 1, the step timer is exercised, and a bus edge that comes too early shows up as a short gap between changes. Holding `ext_busy` high while requests arrive brings the slot overwrite and the DAC-first ordering within reach.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int TW_W    = 32;
  localparam int LVL_W   = 12;
  localparam int FRAME_W = 16;
  localparam logic [TW_W-1:0]  NCO_INIT = 32'h447A_E147;
  localparam logic [LVL_W-1:0] DAC_INIT = 12'd2783;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PARK, ST_SEL, ST_SHIFT, ST_TAIL,
    ST_XLO, ST_XHI, ST_REL, ST_FIN
  } step_e;

  // DAC frame: don't-care pad bits (sent as zero) ahead of the level
  function automatic logic [FRAME_W-1:0] dac_frame(input logic [LVL_W-1:0] lvl);
    return {{(FRAME_W-LVL_W){1'b0}}, lvl};
  endfunction

  // Left-aligned shift image of either payload
  function automatic logic [TW_W-1:0] shift_image(input logic is_dac,
                                                  input logic [LVL_W-1:0] lvl,
                                                  input logic [TW_W-1:0] word);
    if (is_dac) return {dac_frame(lvl), {(TW_W-FRAME_W){1'b0}}};
    return word;
  endfunction
endpackage

// File: rtl/loader_slot.sv
module loader_slot #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] val,
  input  logic         take,
  output logic         pend,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b1;
      word <= INIT;
    end else if (set) begin
      pend <= 1'b1;
      word <= val;
    end else if (take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/loader_tick.sv
module loader_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/loader_engine.sv
module loader_engine
  import loader_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ext_busy,
  input  logic             dac_pend,
  input  logic [LVL_W-1:0] dac_word,
  input  logic             nco_pend,
  input  logic [TW_W-1:0]  nco_word,
  output logic             dac_take,
  output logic             nco_take,
  output logic             launch,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             sdata,
  output logic             nco_sel_n,
  output logic             dac_sel_n,
  output logic             nco_xfer_n
);
  localparam int BW = $clog2(TW_W);

  step_e           st;
  logic            is_dac;
  logic            half;
  logic [BW-1:0]   bits;
  logic [TW_W-1:0] shreg;

  assign launch   = (st == ST_IDLE) && !ext_busy && (dac_pend || nco_pend);
  assign dac_take = launch && dac_pend;
  assign nco_take = launch && !dac_pend;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      is_dac <= 1'b0;
      half   <= 1'b0;
      bits   <= '0;
      shreg  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        is_dac <= dac_pend;
        shreg  <= shift_image(dac_pend, dac_word, nco_word);
        bits   <= dac_pend ? BW'(FRAME_W - 1) : BW'(TW_W - 1);
        half   <= 1'b0;
        st     <= dac_pend ? ST_PARK : ST_SEL;
      end else if (tick) begin
        case (st)
          ST_PARK:  st <= ST_SEL;
          ST_SEL:   st <= ST_SHIFT;
          ST_SHIFT: begin
            if (!half) begin
              half <= 1'b1;
            end else begin
              half  <= 1'b0;
              shreg <= shreg << 1;
              if (bits == '0) st <= ST_TAIL;
              else            bits <= bits - 1'b1;
            end
          end
          ST_TAIL:  st <= is_dac ? ST_REL : ST_XLO;
          ST_XLO:   st <= ST_XHI;
          ST_XHI:   st <= ST_REL;
          ST_REL:   st <= ST_FIN;
          ST_FIN: begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end

  // Bus line decode: the DAC frame holds the clock high outside its low phase
  always_comb begin
    sclk = 1'b0;
    if (st == ST_SHIFT)
      sclk = is_dac ? !half : half;
    else if (is_dac && (st == ST_PARK || st == ST_SEL || st == ST_TAIL || st == ST_REL))
      sclk = 1'b1;
  end

  assign sdata      = (st == ST_SHIFT) && shreg[TW_W-1];
  assign nco_sel_n  = !(!is_dac && (st == ST_SEL || st == ST_SHIFT || st == ST_TAIL ||
                                    st == ST_XLO || st == ST_XHI));
  assign dac_sel_n  = !(is_dac && (st == ST_SEL || st == ST_SHIFT || st == ST_TAIL));
  assign nco_xfer_n = (st != ST_XLO);
endmodule

// File: rtl/osc_dac_loader.sv
module osc_dac_loader
  import loader_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nco_start,
  input  logic [TW_W-1:0]  nco_word,
  input  logic             dac_start,
  input  logic [LVL_W-1:0] dac_level,
  input  logic             ext_busy,
  output logic             busy,
  output logic             sclk,
  output logic             sdata,
  output logic             nco_sel_n,
  output logic             nco_xfer_n,
  output logic             dac_sel_n,
  output logic             done
);
  logic             tick_w, launch_w, step_w;
  logic             dac_pend, nco_pend, dac_take, nco_take;
  logic [LVL_W-1:0] dac_q;
  logic [TW_W-1:0]  nco_q;

  loader_slot #(.W(LVL_W), .INIT(DAC_INIT)) u_dac_slot (
    .clk(clk), .rst_n(rst_n), .set(dac_start), .val(dac_level),
    .take(dac_take), .pend(dac_pend), .word(dac_q));

  loader_slot #(.W(TW_W), .INIT(NCO_INIT)) u_nco_slot (
    .clk(clk), .rst_n(rst_n), .set(nco_start), .val(nco_word),
    .take(nco_take), .pend(nco_pend), .word(nco_q));

  loader_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick_w));

  loader_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .ext_busy(ext_busy),
    .dac_pend(dac_pend), .dac_word(dac_q), .nco_pend(nco_pend), .nco_word(nco_q),
    .dac_take(dac_take), .nco_take(nco_take), .launch(launch_w), .busy(busy),
    .done(done), .sclk(sclk), .sdata(sdata), .nco_sel_n(nco_sel_n),
    .dac_sel_n(dac_sel_n), .nco_xfer_n(nco_xfer_n));

  // Any event that may move a bus line
  assign step_w = tick_w || launch_w;
endmodule

// File: rtl/loader_checker.sv
module loader_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic ext_busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic nco_sel_n,
  input logic dac_sel_n,
  input logic nco_xfer_n,
  input logic step
);
  logic [4:0] lines;
  assign lines = {sclk, sdata, nco_sel_n, dac_sel_n, nco_xfer_n};

  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nco_sel_n && dac_sel_n && nco_xfer_n && !sclk && !sdata));

  a_r2_xfer_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_xfer_n |-> !nco_sel_n);

  a_r3_dac_park: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sel_n) |-> sclk);

  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ext_busy));

  a_r8_step_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lines != $past(lines)) |-> $past(step));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~nco_sel_n, ~dac_sel_n}) <= 1);
endmodule

bind osc_dac_loader loader_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ext_busy(ext_busy), .done(done),
  .sclk(sclk), .sdata(sdata), .nco_sel_n(nco_sel_n), .dac_sel_n(dac_sel_n),
  .nco_xfer_n(nco_xfer_n), .step(step_w));

// File: tb/tb_osc_dac_loader.sv
module tb_osc_dac_loader;
  localparam int DIV = 3;

  typedef struct {
    bit          is_dac;
    logic [31:0] val;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nco_start = 1'b0, dac_start = 1'b0, ext_busy = 1'b0;
  logic [31:0] nco_word = '0;
  logic [11:0] dac_level = '0;
  logic        busy, sclk, sdata, nco_sel_n, nco_xfer_n, dac_sel_n, done;

  int compared = 0, mism = 0, frames = 0, done_cnt = 0;
  bit finished = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  osc_dac_loader #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .nco_start(nco_start), .nco_word(nco_word),
    .dac_start(dac_start), .dac_level(dac_level), .ext_busy(ext_busy),
    .busy(busy), .sclk(sclk), .sdata(sdata), .nco_sel_n(nco_sel_n),
    .nco_xfer_n(nco_xfer_n), .dac_sel_n(dac_sel_n), .done(done));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mism++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit is_dac, input logic [31:0] v, input string req);
    item_t it;
    it.is_dac = is_dac; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic req_dac(input logic [11:0] lvl);
    @(negedge clk); dac_level = lvl; dac_start = 1'b1;
    @(negedge clk); dac_start = 1'b0;
  endtask

  task automatic req_nco(input logic [31:0] w);
    @(negedge clk); nco_word = w; nco_start = 1'b1;
    @(negedge clk); nco_start = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
    repeat (4 * DIV) @(negedge clk);
  endtask

  // Monitor: rebuilds frames from the bus and compares with the scoreboard
  logic        p_sclk = 0, p_sdata = 0, p_nsel = 1, p_dsel = 1, p_xfer = 1;
  logic [31:0] ncap = '0, dcap = '0;
  int          nbits = 0, dbits = 0, gap = 1000;
  bit          xfer_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({sclk, sdata, nco_sel_n, dac_sel_n, nco_xfer_n} !=
          {p_sclk, p_sdata, p_nsel, p_dsel, p_xfer}) begin
        if (gap < DIV) check(0, "R8 edge gap", gap, DIV);
        gap = 1;
      end else gap++;
      if (p_nsel && !nco_sel_n) begin nbits = 0; ncap = '0; xfer_seen = 0; end
      if (!nco_sel_n && !p_sclk && sclk) begin ncap = {ncap[30:0], sdata}; nbits++; end
      if (!nco_sel_n && !p_xfer && nco_xfer_n) begin
        check(nbits == 32, "R2 bits before transfer", nbits, 32);
        xfer_seen = 1;
      end
      if (!p_nsel && nco_sel_n) begin
        item_t it;
        frames++;
        check(xfer_seen, "R2 transfer pulse", xfer_seen, 1);
        if (sb.size() == 0) check(0, "R5 unexpected nco frame", ncap, 0);
        else begin
          it = sb.pop_front();
          check(!it.is_dac && ncap == it.val && nbits == 32, it.req, ncap, it.val);
        end
      end
      if (p_dsel && !dac_sel_n) begin
        check(sclk == 1'b1, "R3 clock parked high", sclk, 1);
        dbits = 0; dcap = '0;
      end
      if (!dac_sel_n && p_sclk && !sclk) begin dcap = {dcap[30:0], sdata}; dbits++; end
      if (!p_dsel && dac_sel_n) begin
        item_t it;
        frames++;
        check(sclk == 1'b1, "R3 clock high at release", sclk, 1);
        if (sb.size() == 0) check(0, "R5 unexpected dac frame", dcap, 0);
        else begin
          it = sb.pop_front();
          check(it.is_dac && dcap == {16'h0, 4'h0, it.val[11:0]} && dbits == 16,
                it.req, dcap, it.val);
        end
      end
      if (done) begin
        done_cnt++;
        if (busy) check(0, "R9 done while busy", busy, 0);
      end
      if (ext_busy && !busy && (!nco_sel_n || !dac_sel_n))
        check(0, "R7 select under ext_busy", 1, 0);
    end
    p_sclk = sclk; p_sdata = sdata; p_nsel = nco_sel_n; p_dsel = dac_sel_n; p_xfer = nco_xfer_n;
  end

  initial begin
    repeat (5) @(negedge clk);
    check({nco_sel_n, dac_sel_n, nco_xfer_n, sclk, sdata} == 5'b11100, "R1 reset levels",
          {nco_sel_n, dac_sel_n, nco_xfer_n, sclk, sdata}, 5'b11100);
    push(1, 32'd2783, "R4 power-up level");
    push(0, 32'h447A_E147, "R4 power-up word");
    rst_n = 1'b1;
    drain();
    check(!busy && sclk == 0 && nco_sel_n && dac_sel_n, "R1 idle after power-up",
          {busy, sclk, nco_sel_n, dac_sel_n}, 4'b0011);

    push(1, 32'd0, "R3 level 0");             req_dac(12'd0);     drain();
    push(1, 32'd4095, "R3 level 4095");       req_dac(12'd4095);  drain();
    push(0, 32'hA5A5_0F0F, "R2 word A5A50F0F"); req_nco(32'hA5A5_0F0F); drain();
    push(0, 32'hFFFF_FFFF, "R2 word all ones"); req_nco(32'hFFFF_FFFF); drain();

    // R5: dac request arrives while the nco frame is running
    push(0, 32'h0000_0001, "R5 first of queued pair");
    push(1, 32'h5A3, "R5 queued dac");
    req_nco(32'h0000_0001);
    repeat (5) @(negedge clk);
    check(busy, "R7 busy during frame", busy, 1);
    req_dac(12'h5A3);
    drain();

    // R5 overwrite while the other master holds the bus
    ext_busy = 1'b1;
    req_dac(12'd100);
    req_dac(12'd200);
    repeat (40) @(negedge clk);
    check(!busy && dac_sel_n, "R7 held off by ext_busy", {busy, dac_sel_n}, 2'b01);
    push(1, 32'd200, "R5 newest value only");
    ext_busy = 1'b0;
    drain();

    // R6: both targets waiting, DAC goes first
    ext_busy = 1'b1;
    req_nco(32'h1234_5678);
    req_dac(12'd7);
    repeat (10) @(negedge clk);
    push(1, 32'd7, "R6 dac first");
    push(0, 32'h1234_5678, "R6 nco second");
    ext_busy = 1'b0;
    drain();

    check(done_cnt == frames && frames == 11, "R9 done count", done_cnt, 11);
    check(sb.size() == 0, "R5 scoreboard empty", sb.size(), 0);
    check({nco_sel_n, dac_sel_n, nco_xfer_n, sclk, sdata} == 5'b11100, "R1 final idle",
          {nco_sel_n, dac_sel_n, nco_xfer_n, sclk, sdata}, 5'b11100);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mism++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end
endmodule